// File: doc/BRIEF.md
# Vectored Interrupt Controller with Fast Path

This block collects 64 level-sensitive peripheral interrupt lines and turns them into two processor requests: a normal request that goes through priority arbitration and a level mask, and a fast request for sources that software has steered to the low-latency path. Software configures it over a simple 32-bit register bus. Any source can be enabled or disabled by writing its number to a command word, so no read-modify-write is needed. Whole enable words can also be written directly.

Each source carries a 4-bit priority and a steering bit. An interrupt handler reads the normal vector word to learn which pending normal source has the highest priority. It reads the fast vector word to learn the highest-numbered pending fast source. Software can also assert any source through force words. It can read the raw line state and both pending sets.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a synchronous reset, the enable words, steering words and force words read 0. Both request outputs are low. Both vector words read 0xFFFFFFFF.
- R2: A write of value n to word offset 0x08 sets the enable bit of source n and leaves all other enable bits unchanged. Source n is bit n%32 of offset 0x14 for n < 32, or of offset 0x10 for n ≥ 32. A value of 64 or more changes nothing.
- R3: A write of value n to word offset 0x0C clears the enable bit of source n and leaves all other bits unchanged. A value of 64 or more changes nothing.
- R4: The enable words (0x10 for sources 63..32, 0x14 for sources 31..0), the steering words (0x18 high, 0x1C low) and the force words (0x50 high, 0x54 low) are written whole and read back unchanged.
- R5: A source is active when its input line or its force bit is 1. The raw input lines read at 0x48 (high) and 0x4C (low).
- R6: The normal pending set is active AND enabled AND steering bit 0. It reads at 0x58/0x5C (high/low). The fast pending set is active AND enabled AND steering bit 1. It reads at 0x60/0x64.
- R7: Priority register x (x = 0..7) sits at offset 0x20 + 4*(7−x). Bits [4j+3:4j] of that register hold the priority of source 8x+j.
- R8: The normal vector word at 0x40 gives the number of the normal-pending source with the largest priority. When priorities tie, the higher source number wins. It reads 0xFFFFFFFF when nothing is normal-pending.
- R9: irq_norm is high exactly when a normal vector is valid and either the mask word at 0x04 is all ones or the winner's priority is strictly greater than mask bits [3:0].
- R10: The fast vector word at 0x44 gives the highest-numbered fast-pending source, or 0xFFFFFFFF if there is none. irq_fast is high exactly when some source is fast-pending.
- R11: Both vector words and both request outputs are registered. They reflect the inputs and register contents of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Level-sensitive interrupt lines, bit n is source n |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Enable-by-number and disable-by-number are swept over every source number, with the neighbouring bits preset to 1 or to 0. The out-of-range values 64, 100 and 0xFFFFFFC0 are also tried. This separates a correct single-bit update from writes into the wrong word, writes that disturb neighbouring bits, and truncated number decoding. A single-source sweep gives each source its own priority against a fixed mask, first on the normal path and then on the fast path. This exposes a broken priority register offset, a broken field position, a broken comparison against the mask, or broken steering. Pseudo-random mixes of lines, forces, enables, steering, priorities and mask then check the pending words, both vectors and both outputs. Deliberate priority ties and the all-ones mask are included, so that tie-breaking toward the higher number and mask bypass are both exercised.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
    localparam int SRC_CNT    = 64;
    localparam int WORD_W     = 32;
    localparam int PRIO_W     = 4;
    localparam int ADDR_W     = 7;
    localparam int IDX_W      = $clog2(SRC_CNT);
    localparam int FLD_PER_RG = WORD_W / PRIO_W;
    localparam int PRIO_REGS  = SRC_CNT / FLD_PER_RG;
    localparam int WSEL_W     = ADDR_W - 2;
    localparam int PRIO_BASE  = 8;

    typedef logic [IDX_W-1:0]  src_idx_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic     valid;
        src_idx_t idx;
    } vec_t;

    typedef enum logic [WSEL_W-1:0] {
        W_LVLMASK = 5'd1,
        W_ENNUM   = 5'd2,
        W_DISNUM  = 5'd3,
        W_ENHI    = 5'd4,
        W_ENLO    = 5'd5,
        W_TYPHI   = 5'd6,
        W_TYPLO   = 5'd7,
        W_NVEC    = 5'd16,
        W_FVEC    = 5'd17,
        W_RAWHI   = 5'd18,
        W_RAWLO   = 5'd19,
        W_FRCHI   = 5'd20,
        W_FRCLO   = 5'd21,
        W_NPHI    = 5'd22,
        W_NPLO    = 5'd23,
        W_FPHI    = 5'd24,
        W_FPLO    = 5'd25
    } word_sel_e;

    function automatic word_t vec_word(vec_t v);
        word_t w;
        w = '1;
        if (v.valid) w = word_t'(v.idx);
        return w;
    endfunction

    function automatic logic [WSEL_W-1:0] prio_word_of(int r);
        return WSEL_W'(PRIO_BASE + PRIO_REGS - 1 - r);
    endfunction
endpackage

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
    import irq_vec_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [WSEL_W-1:0]              wr_word,
    input  word_t                          wr_data,
    output logic [SRC_CNT-1:0]             en_q,
    output logic [SRC_CNT-1:0]             typ_q,
    output logic [SRC_CNT-1:0]             frc_q,
    output logic [SRC_CNT-1:0][PRIO_W-1:0] prio_q,
    output word_t                          mask_q
);
    logic     num_ok;
    src_idx_t num;

    assign num_ok = (wr_data[WORD_W-1:IDX_W] == '0);
    assign num    = wr_data[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            typ_q  <= '0;
            frc_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (wr_word)
                W_LVLMASK: mask_q <= wr_data;
                W_ENNUM:   if (num_ok) en_q[num] <= 1'b1;
                W_DISNUM:  if (num_ok) en_q[num] <= 1'b0;
                W_ENHI:    en_q[SRC_CNT-1:WORD_W]  <= wr_data;
                W_ENLO:    en_q[WORD_W-1:0]        <= wr_data;
                W_TYPHI:   typ_q[SRC_CNT-1:WORD_W] <= wr_data;
                W_TYPLO:   typ_q[WORD_W-1:0]       <= wr_data;
                W_FRCHI:   frc_q[SRC_CNT-1:WORD_W] <= wr_data;
                W_FRCLO:   frc_q[WORD_W-1:0]       <= wr_data;
                default: ;
            endcase
        end
    end

    for (genvar r = 0; r < PRIO_REGS; r++) begin : g_prio
        localparam logic [WSEL_W-1:0] MY_WORD = prio_word_of(r);
        always_ff @(posedge clk) begin
            if (rst)
                prio_q[r*FLD_PER_RG +: FLD_PER_RG] <= '0;
            else if (wr_en && wr_word == MY_WORD)
                prio_q[r*FLD_PER_RG +: FLD_PER_RG] <= wr_data;
        end
    end
endmodule

// File: rtl/irq_vec_prio_sel.sv
module irq_vec_prio_sel
    import irq_vec_pkg::*;
(
    input  logic [SRC_CNT-1:0]             pend,
    input  logic [SRC_CNT-1:0][PRIO_W-1:0] prio,
    output vec_t                           win,
    output prio_t                          win_prio
);
    always_comb begin
        win      = '0;
        win_prio = '0;
        for (int i = 0; i < SRC_CNT; i++) begin
            if (pend[i] && (!win.valid || prio[i] >= win_prio)) begin
                win.valid = 1'b1;
                win.idx   = src_idx_t'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_vec_top_sel.sv
module irq_vec_top_sel
    import irq_vec_pkg::*;
(
    input  logic [SRC_CNT-1:0] pend,
    output vec_t               win
);
    always_comb begin
        win = '0;
        for (int i = 0; i < SRC_CNT; i++) begin
            if (pend[i]) begin
                win.valid = 1'b1;
                win.idx   = src_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SRC_CNT-1:0]  src_in,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    output logic                irq_norm,
    output logic                irq_fast
);
    logic [SRC_CNT-1:0]             en_q, typ_q, frc_q;
    logic [SRC_CNT-1:0][PRIO_W-1:0] prio_q;
    word_t                          mask_q;
    logic [SRC_CNT-1:0]             active, norm_pend, fast_pend;
    logic [WSEL_W-1:0]              word;
    vec_t                           norm_win, fast_win, nvec_q, fvec_q;
    prio_t                          norm_prio;
    logic                           lvl_pass;

    assign word = bus_addr[ADDR_W-1:2];

    irq_vec_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .wr_word (word),
        .wr_data (bus_wdata),
        .en_q    (en_q),
        .typ_q   (typ_q),
        .frc_q   (frc_q),
        .prio_q  (prio_q),
        .mask_q  (mask_q)
    );

    assign active    = src_in | frc_q;
    assign norm_pend = active & en_q & ~typ_q;
    assign fast_pend = active & en_q & typ_q;

    irq_vec_prio_sel u_nsel (
        .pend     (norm_pend),
        .prio     (prio_q),
        .win      (norm_win),
        .win_prio (norm_prio)
    );

    irq_vec_top_sel u_fsel (
        .pend (fast_pend),
        .win  (fast_win)
    );

    assign lvl_pass = (mask_q == '1) || (norm_prio > mask_q[PRIO_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            nvec_q   <= '0;
            fvec_q   <= '0;
            irq_norm <= 1'b0;
            irq_fast <= 1'b0;
        end else begin
            nvec_q   <= norm_win;
            fvec_q   <= fast_win;
            irq_norm <= norm_win.valid && lvl_pass;
            irq_fast <= fast_win.valid;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (word)
            W_LVLMASK: bus_rdata = mask_q;
            W_ENHI:    bus_rdata = en_q[SRC_CNT-1:WORD_W];
            W_ENLO:    bus_rdata = en_q[WORD_W-1:0];
            W_TYPHI:   bus_rdata = typ_q[SRC_CNT-1:WORD_W];
            W_TYPLO:   bus_rdata = typ_q[WORD_W-1:0];
            W_NVEC:    bus_rdata = vec_word(nvec_q);
            W_FVEC:    bus_rdata = vec_word(fvec_q);
            W_RAWHI:   bus_rdata = src_in[SRC_CNT-1:WORD_W];
            W_RAWLO:   bus_rdata = src_in[WORD_W-1:0];
            W_FRCHI:   bus_rdata = frc_q[SRC_CNT-1:WORD_W];
            W_FRCLO:   bus_rdata = frc_q[WORD_W-1:0];
            W_NPHI:    bus_rdata = norm_pend[SRC_CNT-1:WORD_W];
            W_NPLO:    bus_rdata = norm_pend[WORD_W-1:0];
            W_FPHI:    bus_rdata = fast_pend[SRC_CNT-1:WORD_W];
            W_FPLO:    bus_rdata = fast_pend[WORD_W-1:0];
            default: begin
                for (int r = 0; r < PRIO_REGS; r++)
                    if (word == prio_word_of(r))
                        bus_rdata = prio_q[r*FLD_PER_RG +: FLD_PER_RG];
            end
        endcase
    end
endmodule

// File: rtl/irq_vec_chk.sv
module irq_vec_chk
    import irq_vec_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [WORD_W-1:0]  bus_wdata,
    input logic [SRC_CNT-1:0] en,
    input logic [SRC_CNT-1:0] fpend,
    input logic               nvec_valid,
    input logic               irq_norm,
    input logic               irq_fast
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    logic num_wr_ok;
    assign num_wr_ok = bus_wr && bus_wdata[WORD_W-1:IDX_W] == '0;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_norm && !irq_fast));

    p_enable_num_r2: assert property (@(posedge clk) disable iff (rst || !armed)
        (num_wr_ok && bus_addr[ADDR_W-1:2] == W_ENNUM)
        |=> en[$past(bus_wdata[IDX_W-1:0])]);

    p_disable_num_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (num_wr_ok && bus_addr[ADDR_W-1:2] == W_DISNUM)
        |=> !en[$past(bus_wdata[IDX_W-1:0])]);

    p_norm_needs_vec_r9: assert property (@(posedge clk) disable iff (rst || !armed)
        irq_norm |-> nvec_valid);

    p_fast_follows_pend_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        irq_fast == $past(|fpend));
endmodule

bind irq_vec_ctrl irq_vec_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .en         (en_q),
    .fpend      (fast_pend),
    .nvec_valid (nvec_q.valid),
    .irq_norm   (irq_norm),
    .irq_fast   (irq_fast)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm, irq_fast;

    int checks = 0;
    int fails  = 0;

    logic [63:0] m_en, m_typ, m_frc;
    logic [3:0]  m_prio [64];
    logic [31:0] m_mask;
    logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst(rst), .src_in(src_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [63:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        return seed;
    endfunction

    function automatic logic [6:0] prio_addr(int x);
        return 7'(32 + 4 * (7 - x));
    endfunction

    task automatic push_cfg();
        wr(7'h10, m_en[63:32]);  wr(7'h14, m_en[31:0]);
        wr(7'h18, m_typ[63:32]); wr(7'h1C, m_typ[31:0]);
        wr(7'h50, m_frc[63:32]); wr(7'h54, m_frc[31:0]);
        for (int x = 0; x < 8; x++) begin
            logic [31:0] w;
            for (int j = 0; j < 8; j++) w[4*j +: 4] = m_prio[8*x + j];
            wr(prio_addr(x), w);
        end
        wr(7'h04, m_mask);
    endtask

    // Expected outcome from R6, R8, R9, R10
    task automatic check_outcome(input string tag);
        logic [63:0] act, np, fp;
        logic [31:0] d, en_vec, ef_vec;
        logic        nv, fv, exp_irqn;
        int          bi, bp, fi;
        act = src_in | m_frc;
        np  = act & m_en & ~m_typ;
        fp  = act & m_en & m_typ;
        nv = 1'b0; bi = 0; bp = 0; fv = 1'b0; fi = 0;
        for (int i = 0; i < 64; i++) begin
            if (np[i] && (!nv || int'(m_prio[i]) >= bp)) begin
                nv = 1'b1; bi = i; bp = int'(m_prio[i]);
            end
            if (fp[i]) begin fv = 1'b1; fi = i; end
        end
        en_vec = nv ? 32'(bi) : 32'hFFFF_FFFF;
        ef_vec = fv ? 32'(fi) : 32'hFFFF_FFFF;
        exp_irqn = nv && (m_mask == 32'hFFFF_FFFF || bp > int'(m_mask[3:0]));
        @(negedge clk); // R11: registered outputs settle one edge later
        chk({tag, " R9 irq_norm"}, 64'(irq_norm), 64'(exp_irqn));
        chk({tag, " R10 irq_fast"}, 64'(irq_fast), 64'(fv));
        rd(7'h40, d); chk({tag, " R8 normal vector"}, 64'(d), 64'(en_vec));
        rd(7'h44, d); chk({tag, " R10 fast vector"}, 64'(d), 64'(ef_vec));
        rd(7'h58, d); chk({tag, " R6 npend hi"}, 64'(d), 64'(np[63:32]));
        rd(7'h5C, d); chk({tag, " R6 npend lo"}, 64'(d), 64'(np[31:0]));
        rd(7'h60, d); chk({tag, " R6 fpend hi"}, 64'(d), 64'(fp[63:32]));
        rd(7'h64, d); chk({tag, " R6 fpend lo"}, 64'(d), 64'(fp[31:0]));
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [63:0] e;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq_norm", 64'(irq_norm), 64'd0);
        chk("R1 irq_fast", 64'(irq_fast), 64'd0);
        rd(7'h10, d); chk("R1 en hi", 64'(d), 0);
        rd(7'h14, d); chk("R1 en lo", 64'(d), 0);
        rd(7'h18, d); chk("R1 typ hi", 64'(d), 0);
        rd(7'h1C, d); chk("R1 typ lo", 64'(d), 0);
        rd(7'h50, d); chk("R1 frc hi", 64'(d), 0);
        rd(7'h54, d); chk("R1 frc lo", 64'(d), 0);
        rd(7'h40, d); chk("R1 nvec", 64'(d), 64'hFFFF_FFFF);
        rd(7'h44, d); chk("R1 fvec", 64'(d), 64'hFFFF_FFFF);

        // R2: enable by number, every source, from all-zero
        e = '0;
        for (int n = 0; n < 64; n++) begin
            wr(7'h08, 32'(n));
            e[n] = 1'b1;
            rd(7'h10, d); chk("R2 en hi after set", 64'(d), 64'(e[63:32]));
            rd(7'h14, d); chk("R2 en lo after set", 64'(d), 64'(e[31:0]));
        end
        // R3: disable by number, every source, from all-ones
        for (int n = 63; n >= 0; n--) begin
            wr(7'h0C, 32'(n));
            e[n] = 1'b0;
            rd(7'h10, d); chk("R3 en hi after clear", 64'(d), 64'(e[63:32]));
            rd(7'h14, d); chk("R3 en lo after clear", 64'(d), 64'(e[31:0]));
        end
        // R2/R3: out-of-range numbers ignored
        wr(7'h14, 32'h0000_0001);
        wr(7'h10, 32'h8000_0000);
        wr(7'h08, 32'd64); wr(7'h08, 32'd100); wr(7'h08, 32'hFFFF_FFC0);
        rd(7'h10, d); chk("R2 ignore >=64 hi", 64'(d), 64'h8000_0000);
        rd(7'h14, d); chk("R2 ignore >=64 lo", 64'(d), 64'h0000_0001);
        wr(7'h0C, 32'd64); wr(7'h0C, 32'd127); wr(7'h0C, 32'hFFFF_FFFF);
        rd(7'h10, d); chk("R3 ignore >=64 hi", 64'(d), 64'h8000_0000);
        rd(7'h14, d); chk("R3 ignore >=64 lo", 64'(d), 64'h0000_0001);

        // R4: word writes read back
        wr(7'h10, 32'hA5A5_0F0F); rd(7'h10, d); chk("R4 en hi", 64'(d), 64'hA5A5_0F0F);
        wr(7'h14, 32'h1234_5678); rd(7'h14, d); chk("R4 en lo", 64'(d), 64'h1234_5678);
        wr(7'h18, 32'hDEAD_BEEF); rd(7'h18, d); chk("R4 typ hi", 64'(d), 64'hDEAD_BEEF);
        wr(7'h1C, 32'h0BAD_F00D); rd(7'h1C, d); chk("R4 typ lo", 64'(d), 64'h0BAD_F00D);
        wr(7'h50, 32'hC0DE_0001); rd(7'h50, d); chk("R4 frc hi", 64'(d), 64'hC0DE_0001);
        wr(7'h54, 32'h7000_0007); rd(7'h54, d); chk("R4 frc lo", 64'(d), 64'h7000_0007);

        // R5: raw lines
        src_in = 64'h0123_4567_89AB_CDEF;
        rd(7'h48, d); chk("R5 raw hi", 64'(d), 64'h0123_4567);
        rd(7'h4C, d); chk("R5 raw lo", 64'(d), 64'h89AB_CDEF);

        // R7: priority register placement
        for (int x = 0; x < 8; x++) wr(prio_addr(x), 32'h1111_1111 * (x + 1));
        for (int x = 0; x < 8; x++) begin
            rd(prio_addr(x), d);
            chk("R7 prio readback", 64'(d), 64'(32'h1111_1111 * (x + 1)));
        end

        // R8/R9/R10: single-source sweep, normal then fast
        m_frc = '0; m_typ = '0; m_mask = 32'd7;
        for (int i = 0; i < 64; i++) m_prio[i] = 4'(i % 16);
        for (int n = 0; n < 64; n++) begin
            m_en = '0; m_en[n] = 1'b1;
            m_typ = '0;
            src_in = '0; src_in[n] = 1'b1;
            push_cfg();
            check_outcome("sweep normal");
            m_typ[n] = 1'b1;
            wr(7'h18, m_typ[63:32]); wr(7'h1C, m_typ[31:0]);
            check_outcome("sweep fast");
        end

        // R8: tie goes to higher number, R9 mask all ones bypass
        for (int i = 0; i < 64; i++) m_prio[i] = 4'd0;
        m_prio[5] = 4'd9; m_prio[40] = 4'd9; m_prio[62] = 4'd3;
        m_en = '1; m_typ = '0; m_frc = '0; m_mask = 32'hFFFF_FFFF;
        src_in = '0; src_in[5] = 1'b1; src_in[40] = 1'b1; src_in[62] = 1'b1;
        push_cfg();
        check_outcome("R8 tie");
        m_mask = 32'h0000_0009; wr(7'h04, m_mask);
        check_outcome("R9 equal to mask blocks");
        m_mask = 32'h0000_0010; wr(7'h04, m_mask);
        check_outcome("R9 upper mask bits ignored");
        // R5: force only
        src_in = '0; m_frc = 64'h0000_0400_0000_0000;
        wr(7'h50, m_frc[63:32]); wr(7'h54, m_frc[31:0]);
        check_outcome("R5 forced source");

        // Random mixes
        for (int k = 0; k < 60; k++) begin
            logic [63:0] r;
            m_en  = rnd();
            m_typ = rnd();
            m_frc = rnd() & rnd() & rnd();
            for (int x = 0; x < 8; x++) begin
                r = rnd();
                for (int j = 0; j < 8; j++) m_prio[8*x + j] = r[4*j +: 4];
            end
            r = rnd();
            case (k % 4)
                0: m_mask = 32'hFFFF_FFFF;
                1: m_mask = 32'd0;
                default: m_mask = 32'(r[3:0]);
            endcase
            if (k % 5 == 0) begin
                for (int i = 0; i < 64; i++) m_prio[i] = 4'd6;
            end
            push_cfg();
            src_in = (k % 7 == 0) ? 64'd0 : (rnd() & rnd());
            check_outcome("random mix");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule